// File: doc/BRIEF.md
# Branch and Jump Resolution Unit

This unit settles control flow for a small 32-bit RISC pipeline that has one architectural delay slot. For each accepted instruction word it decides whether the word is a control transfer. If it is, the unit computes whether the transfer is taken and where it goes. It also raises a request to write a return address into r31 for the linking jumps. Byte offsets are sign-extended and added to the address that follows the control word. Register-indirect jumps take their destination straight from a source register value. Conditional branches test only a single register for zero or non-zero, or a floating-point condition flag.

A two-state controller tracks the delay slot. In state `S_RUN` the unit resolves control words. The transition `RUN_TO_SLOT` fires when a control word is accepted. In state `S_SLOT` the next valid word is the delay slot: it always executes and is never resolved as control. The transition `SLOT_TO_RUN` fires when that word is accepted. On that transition the unit emits a one-cycle redirect carrying the stored target, provided the transfer was taken. Invalid cycles hold either state (`RUN_HOLD`, `SLOT_HOLD`). Two counters record how often conditional branches were taken and not taken.

Top module: `bru_unit`

## Requirements
- R1: While rst_n is low and on the first cycle after it, ctl_o, taken_o, link_we_o, slot_o and redirect_o are 0 and both counters read 0.
- R2: Only opcodes (instr[31:26]) 0x02 J, 0x03 JAL, 0x04 BEQZ, 0x05 BNEZ, 0x06 BFPT, 0x07 BFPF, 0x12 JR and 0x13 JALR are control words. Any other opcode, including 0x10 and 0x11, gives ctl_o = 0.
- R3: For opcodes 0x04 to 0x07 the target is pc + 4 + the sign-extended byte offset in instr[15:0].
- R4: For J and JAL the target is pc + 4 + the sign-extended byte offset in instr[25:0]. Both are always taken.
- R5: For JR and JALR the target is rs1_val. Both are always taken.
- R6: BEQZ is taken when rs1_val is zero. BNEZ is taken when rs1_val is non-zero.
- R7: BFPT is taken when fp_flag is 1. BFPF is taken when fp_flag is 0.
- R8: JAL and JALR assert link_we_o with link_val_o = pc + 8. No other word asserts link_we_o.
- R9: A resolved control word moves the unit to S_SLOT (slot_o = 1). The next valid word leaves S_SLOT, and in the cycle after it redirect_o pulses with redirect_pc_o = target, only if the transfer was taken. Cycles with instr_valid = 0 do not end the slot.
- R10: A control opcode arriving as the delay-slot word is not resolved. It gives ctl_o = 0, no link request and no counter change.
- R11: Only resolved BEQZ, BNEZ, BFPT and BFPF words change the counters: taken_cnt_o by one when taken, untaken_cnt_o by one otherwise.
- R12: ctl_o, taken_o, target_o, link_we_o and link_val_o are registered. They describe the word accepted on the previous clock edge, and ctl_o, taken_o and link_we_o are 0 after an edge with no resolved control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | instr, pc, rs1_val and fp_flag hold an accepted word |
| instr | input | 32 | Instruction word |
| pc | input | XLEN | Address of the instruction word |
| rs1_val | input | XLEN | Value of the register named in instr[25:21] |
| fp_flag | input | 1 | Floating-point condition flag |
| ctl_o | output | 1 | Previous word was resolved as control |
| taken_o | output | 1 | That control word is taken |
| target_o | output | XLEN | Its destination address |
| link_we_o | output | 1 | Write link_val_o into r31 |
| link_val_o | output | XLEN | Return address pc + 8 |
| slot_o | output | 1 | Unit is in S_SLOT, waiting for the delay-slot word |
| redirect_o | output | 1 | One-cycle fetch redirect after the delay slot |
| redirect_pc_o | output | XLEN | Redirect address |
| taken_cnt_o | output | CNT_W | Taken conditional branches |
| untaken_cnt_o | output | CNT_W | Untaken conditional branches |

## Verification
The checker watches relations between outputs on every cycle. A resolved word always lands in S_SLOT, and a redirect only follows S_SLOT. A link request implies a taken control word. The counters never move together, and they move only alongside a resolved word of the right outcome. Target arithmetic, the zero and flag conditions, the opcode map and the suppression of control words in the slot depend on instruction contents. Only the bench's directed and random scenarios, compared against its own model, can show those.

// File: rtl/bru_pkg.sv
`timescale 1ns/1ps
package bru_pkg;
    localparam logic [5:0] OPC_J    = 6'h02;
    localparam logic [5:0] OPC_JAL  = 6'h03;
    localparam logic [5:0] OPC_BEQZ = 6'h04;
    localparam logic [5:0] OPC_BNEZ = 6'h05;
    localparam logic [5:0] OPC_BFPT = 6'h06;
    localparam logic [5:0] OPC_BFPF = 6'h07;
    localparam logic [5:0] OPC_JR   = 6'h12;
    localparam logic [5:0] OPC_JALR = 6'h13;

    typedef enum logic [2:0] {
        K_NONE,
        K_JREL,
        K_JREG,
        K_BZ,
        K_BNZ,
        K_BFT,
        K_BFF
    } kind_e;

    typedef struct packed {
        kind_e kind;
        logic  link;
        logic  cond;
    } dec_t;

    typedef enum logic {
        S_RUN,
        S_SLOT
    } state_e;
endpackage

// File: rtl/bru_decode.sv
`timescale 1ns/1ps
module bru_decode
    import bru_pkg::*;
(
    input  logic [31:0] instr,
    output dec_t        dec
);
    logic [5:0] opc;
    assign opc = instr[31:26];

    always_comb begin
        dec = '{kind: K_NONE, link: 1'b0, cond: 1'b0};
        case (opc)
            OPC_J:    dec.kind = K_JREL;
            OPC_JAL:  begin dec.kind = K_JREL; dec.link = 1'b1; end
            OPC_JR:   dec.kind = K_JREG;
            OPC_JALR: begin dec.kind = K_JREG; dec.link = 1'b1; end
            OPC_BEQZ: begin dec.kind = K_BZ;   dec.cond = 1'b1; end
            OPC_BNEZ: begin dec.kind = K_BNZ;  dec.cond = 1'b1; end
            OPC_BFPT: begin dec.kind = K_BFT;  dec.cond = 1'b1; end
            OPC_BFPF: begin dec.kind = K_BFF;  dec.cond = 1'b1; end
            default:  dec.kind = K_NONE;
        endcase
    end
endmodule

// File: rtl/bru_target.sv
`timescale 1ns/1ps
module bru_target
    import bru_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  dec_t            dec,
    input  logic [31:0]     instr,
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] rs1_val,
    input  logic            fp_flag,
    output logic            taken,
    output logic [XLEN-1:0] target
);
    localparam int IMM_W = 16;
    localparam int OFF_W = 26;

    logic [XLEN-1:0] seq_pc;
    logic [XLEN-1:0] imm_x;
    logic [XLEN-1:0] off_x;
    logic            rs1_zero;

    assign seq_pc   = pc + XLEN'(4);
    assign imm_x    = {{(XLEN-IMM_W){instr[IMM_W-1]}}, instr[IMM_W-1:0]};
    assign off_x    = {{(XLEN-OFF_W){instr[OFF_W-1]}}, instr[OFF_W-1:0]};
    assign rs1_zero = (rs1_val == '0);

    always_comb begin
        taken  = 1'b0;
        target = seq_pc + imm_x;
        unique case (dec.kind)
            K_JREL: begin taken = 1'b1; target = seq_pc + off_x; end
            K_JREG: begin taken = 1'b1; target = rs1_val; end
            K_BZ:   taken = rs1_zero;
            K_BNZ:  taken = !rs1_zero;
            K_BFT:  taken = fp_flag;
            K_BFF:  taken = !fp_flag;
            default: taken = 1'b0;
        endcase
    end
endmodule

// File: rtl/bru_stats.sv
`timescale 1ns/1ps
module bru_stats #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd,
    input  logic             taken,
    output logic [CNT_W-1:0] taken_cnt,
    output logic [CNT_W-1:0] untaken_cnt
);
    localparam int NCNT = 2;

    logic [NCNT-1:0]            hit;
    logic [NCNT-1:0][CNT_W-1:0] cnt_q;

    assign hit[0] = upd && taken;
    assign hit[1] = upd && !taken;

    for (genvar g = 0; g < NCNT; g++) begin : g_cnt
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cnt_q[g] <= '0;
            end else if (hit[g]) begin
                cnt_q[g] <= cnt_q[g] + CNT_W'(1);
            end
        end
    end

    assign taken_cnt   = cnt_q[0];
    assign untaken_cnt = cnt_q[1];
endmodule

// File: rtl/bru_unit.sv
`timescale 1ns/1ps
module bru_unit
    import bru_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             instr_valid,
    input  logic [31:0]      instr,
    input  logic [XLEN-1:0]  pc,
    input  logic [XLEN-1:0]  rs1_val,
    input  logic             fp_flag,
    output logic             ctl_o,
    output logic             taken_o,
    output logic [XLEN-1:0]  target_o,
    output logic             link_we_o,
    output logic [XLEN-1:0]  link_val_o,
    output logic             slot_o,
    output logic             redirect_o,
    output logic [XLEN-1:0]  redirect_pc_o,
    output logic [CNT_W-1:0] taken_cnt_o,
    output logic [CNT_W-1:0] untaken_cnt_o
);
    localparam logic [XLEN-1:0] LINK_STEP = XLEN'(8);

    state_e          state_q;
    state_e          state_d;
    dec_t            dec;
    logic            res_taken;
    logic [XLEN-1:0] res_target;
    logic            accept_ctl;
    logic            slot_done;
    logic            pend_taken_q;
    logic [XLEN-1:0] pend_target_q;

    bru_decode u_dec (
        .instr (instr),
        .dec   (dec)
    );

    bru_target #(.XLEN(XLEN)) u_tgt (
        .dec     (dec),
        .instr   (instr),
        .pc      (pc),
        .rs1_val (rs1_val),
        .fp_flag (fp_flag),
        .taken   (res_taken),
        .target  (res_target)
    );

    assign accept_ctl = instr_valid && (state_q == S_RUN) && (dec.kind != K_NONE);
    assign slot_done  = instr_valid && (state_q == S_SLOT);

    bru_stats #(.CNT_W(CNT_W)) u_stats (
        .clk         (clk),
        .rst_n       (rst_n),
        .upd         (accept_ctl && dec.cond),
        .taken       (res_taken),
        .taken_cnt   (taken_cnt_o),
        .untaken_cnt (untaken_cnt_o)
    );

    // next-state logic: RUN_TO_SLOT, RUN_HOLD, SLOT_TO_RUN, SLOT_HOLD
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_RUN:  if (accept_ctl) state_d = S_SLOT;
            S_SLOT: if (slot_done)  state_d = S_RUN;
            default: state_d = S_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_o         <= 1'b0;
            taken_o       <= 1'b0;
            target_o      <= '0;
            link_we_o     <= 1'b0;
            link_val_o    <= '0;
            redirect_o    <= 1'b0;
            redirect_pc_o <= '0;
            pend_taken_q  <= 1'b0;
            pend_target_q <= '0;
        end else begin
            ctl_o      <= accept_ctl;
            taken_o    <= accept_ctl && res_taken;
            link_we_o  <= accept_ctl && dec.link;
            redirect_o <= slot_done && pend_taken_q;
            if (accept_ctl) begin
                target_o      <= res_target;
                link_val_o    <= pc + LINK_STEP;
                pend_taken_q  <= res_taken;
                pend_target_q <= res_target;
            end
            if (slot_done && pend_taken_q) begin
                redirect_pc_o <= pend_target_q;
            end
        end
    end

    assign slot_o = (state_q == S_SLOT);
endmodule

// File: rtl/bru_unit_chk.sv
`timescale 1ns/1ps
module bru_unit_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             instr_valid,
    input logic             ctl_o,
    input logic             taken_o,
    input logic             link_we_o,
    input logic             slot_o,
    input logic             redirect_o,
    input logic [CNT_W-1:0] taken_cnt_o,
    input logic [CNT_W-1:0] untaken_cnt_o
);
    // R9
    ctl_enters_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_o |-> slot_o);

    // R9
    redirect_after_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |-> ($past(slot_o) && $past(instr_valid) && !slot_o));

    // R8
    link_needs_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_we_o |-> (ctl_o && taken_o));

    // R11
    cnt_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!$stable(taken_cnt_o) && !$stable(untaken_cnt_o)));

    // R11
    taken_cnt_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(taken_cnt_o) |-> (ctl_o && taken_o));

    // R11
    untaken_cnt_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(untaken_cnt_o) |-> (ctl_o && !taken_o));

    // R12
    ctl_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_o |-> $past(instr_valid));

    // R9
    slot_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(slot_o) && !$past(instr_valid)) |-> slot_o);
endmodule

bind bru_unit bru_unit_chk #(.CNT_W(CNT_W)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .instr_valid   (instr_valid),
    .ctl_o         (ctl_o),
    .taken_o       (taken_o),
    .link_we_o     (link_we_o),
    .slot_o        (slot_o),
    .redirect_o    (redirect_o),
    .taken_cnt_o   (taken_cnt_o),
    .untaken_cnt_o (untaken_cnt_o)
);

// File: tb/bru_unit_tb_top.sv
`timescale 1ns/1ps
module bru_unit_tb_top;
    localparam int XLEN  = 32;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             instr_valid = 1'b0;
    logic [31:0]      instr = '0;
    logic [XLEN-1:0]  pc = '0;
    logic [XLEN-1:0]  rs1_val = '0;
    logic             fp_flag = 1'b0;
    logic             ctl_o, taken_o, link_we_o, slot_o, redirect_o;
    logic [XLEN-1:0]  target_o, link_val_o, redirect_pc_o;
    logic [CNT_W-1:0] taken_cnt_o, untaken_cnt_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // bench model state
    bit               m_slot = 0;
    bit               m_ptk = 0;
    logic [31:0]      m_ptg = '0;
    int unsigned      m_tcnt = 0;
    int unsigned      m_ucnt = 0;

    always #5 clk = ~clk;

    bru_unit #(.XLEN(XLEN), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
        .pc(pc), .rs1_val(rs1_val), .fp_flag(fp_flag), .ctl_o(ctl_o),
        .taken_o(taken_o), .target_o(target_o), .link_we_o(link_we_o),
        .link_val_o(link_val_o), .slot_o(slot_o), .redirect_o(redirect_o),
        .redirect_pc_o(redirect_pc_o), .taken_cnt_o(taken_cnt_o),
        .untaken_cnt_o(untaken_cnt_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // expected resolution from the requirements
    task automatic resolve(input logic [31:0] ins, input logic [31:0] p, input logic [31:0] r,
                           input logic fp, output bit c, output bit t, output logic [31:0] tg,
                           output bit lk, output bit cnd, output string ttag, output string gtag);
        logic [31:0] s16, s26;
        s16 = {{16{ins[15]}}, ins[15:0]};
        s26 = {{6{ins[25]}}, ins[25:0]};
        c = 1; t = 0; tg = p + 32'd4 + s16; lk = 0; cnd = 0; ttag = "R6"; gtag = "R3";
        case (ins[31:26])
            6'h02: begin t = 1; tg = p + 32'd4 + s26; ttag = "R4"; gtag = "R4"; end
            6'h03: begin t = 1; tg = p + 32'd4 + s26; lk = 1; ttag = "R4"; gtag = "R4"; end
            6'h12: begin t = 1; tg = r; ttag = "R5"; gtag = "R5"; end
            6'h13: begin t = 1; tg = r; lk = 1; ttag = "R5"; gtag = "R5"; end
            6'h04: begin t = (r == 0); cnd = 1; end
            6'h05: begin t = (r != 0); cnd = 1; end
            6'h06: begin t = fp; cnd = 1; ttag = "R7"; end
            6'h07: begin t = !fp; cnd = 1; ttag = "R7"; end
            default: c = 0;
        endcase
    endtask

    // called at a negedge; drives one cycle and checks results at the next negedge
    task automatic step(input bit v, input logic [31:0] ins, input logic [31:0] p,
                        input logic [31:0] r, input bit fp);
        bit c, t, lk, cnd, e_ctl, e_tk, e_lk, e_red, was_slot, is_ctl_op;
        logic [31:0] tg, e_rpc;
        string ttag, gtag, ctag;
        resolve(ins, p, r, fp, c, t, tg, lk, cnd, ttag, gtag);
        is_ctl_op = c;
        was_slot = m_slot;
        e_ctl = v && !m_slot && c;
        e_tk  = e_ctl && t;
        e_lk  = e_ctl && lk;
        e_red = v && m_slot && m_ptk;
        e_rpc = m_ptg;
        if (e_ctl && cnd) begin
            if (t) m_tcnt++; else m_ucnt++;
        end
        if (v && m_slot) m_slot = 0;
        else if (e_ctl) begin m_slot = 1; m_ptk = t; m_ptg = tg; end
        instr_valid = v; instr = ins; pc = p; rs1_val = r; fp_flag = fp;
        @(negedge clk);
        ctag = !v ? "R12" : (was_slot && is_ctl_op) ? "R10" : is_ctl_op ? "R12" : "R2";
        chk(ctag, 32'(ctl_o), 32'(e_ctl));
        chk(e_ctl ? ttag : "R12", 32'(taken_o), 32'(e_tk));
        if (e_ctl) chk(gtag, target_o, tg);
        chk(was_slot ? "R10" : "R8", 32'(link_we_o), 32'(e_lk));
        if (e_lk) chk("R8", link_val_o, p + 32'd8);
        chk("R9", 32'(slot_o), 32'(m_slot));
        chk("R9", 32'(redirect_o), 32'(e_red));
        if (e_red) chk("R9", redirect_pc_o, e_rpc);
        chk(was_slot ? "R10" : "R11", 32'(taken_cnt_o), m_tcnt);
        chk("R11", 32'(untaken_cnt_o), m_ucnt);
    endtask

    function automatic logic [31:0] mk(input logic [5:0] op, input logic [25:0] f);
        return {op, f};
    endfunction

    initial begin
        int unsigned seed;
        logic [5:0] ops [12];
        seed = 32'd1234;
        void'($urandom(seed));
        ops = '{6'h02, 6'h03, 6'h04, 6'h05, 6'h06, 6'h07, 6'h12, 6'h13,
                6'h10, 6'h11, 6'h00, 6'h08};
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", 32'({ctl_o, taken_o, link_we_o, slot_o, redirect_o}), 32'd0);
        chk("R1", 32'(taken_cnt_o), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", 32'({ctl_o, taken_o, link_we_o, slot_o, redirect_o}), 32'd0);
        chk("R1", 32'(untaken_cnt_o), 32'd0);

        // directed: R6 BEQZ taken with negative offset, slot then redirect
        step(1, mk(6'h04, 26'h000fff0), 32'h100, 32'h0, 0);
        step(1, mk(6'h00, 26'h0), 32'h104, 32'h5, 0);
        // R6 BNEZ with zero register: untaken, no redirect
        step(1, mk(6'h05, 26'h0000040), 32'h200, 32'h0, 0);
        step(1, mk(6'h08, 26'h0), 32'h204, 32'h0, 0);
        // R7 BFPT / BFPF
        step(1, mk(6'h06, 26'h0000010), 32'h300, 32'h1, 1);
        step(1, mk(6'h00, 26'h0), 32'h304, 32'h0, 0);
        step(1, mk(6'h07, 26'h0000010), 32'h400, 32'h1, 1);
        step(1, mk(6'h00, 26'h0), 32'h404, 32'h0, 0);
        // R4 J with most negative 26-bit offset, idle cycles in slot (R9)
        step(1, mk(6'h02, 26'h2000000), 32'h0400_0000, 32'h0, 0);
        step(0, mk(6'h00, 26'h0), 32'h0, 32'h0, 0);
        step(0, mk(6'h00, 26'h0), 32'h0, 32'h0, 0);
        step(1, mk(6'h00, 26'h0), 32'h0400_0004, 32'h0, 0);
        // R8/R5 JALR, then R10 control word in the slot
        step(1, mk(6'h13, 26'h0), 32'h800, 32'hdead_beec, 0);
        step(1, mk(6'h04, 26'h0000020), 32'h804, 32'h0, 0);
        // R8 JAL
        step(1, mk(6'h03, 26'h0000100), 32'h900, 32'h0, 0);
        step(1, mk(6'h00, 26'h0), 32'h904, 32'h0, 0);
        // R2 non-control opcodes 0x10 / 0x11
        step(1, mk(6'h10, 26'h3ffffff), 32'ha00, 32'h0, 0);
        step(1, mk(6'h11, 26'h3ffffff), 32'ha04, 32'h0, 0);

        // constrained random mix
        for (int i = 0; i < 600; i++) begin
            logic [5:0] op;
            logic [31:0] r;
            bit v;
            op = ($urandom_range(0, 9) == 0) ? 6'($urandom) : ops[$urandom_range(0, 11)];
            r  = ($urandom_range(0, 3) == 0) ? 32'h0 : $urandom;
            v  = ($urandom_range(0, 9) != 0);
            step(v, mk(op, 26'($urandom)), {$urandom} & 32'hffff_fffc, r, 1'($urandom));
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule